// File: doc/BRIEF.md
# Tap Position Counter with Bus-Driven Stepping

This block holds the 6-bit wiper position of one potentiometer channel. It decodes that position into 64 tap-enable outputs, and exactly one of them is high at any time. The position register can be changed in four ways:

- a power-up recall value;
- a direct write from the bus decoder;
- a parallel load from a selected storage register;
- single steps.

Single steps are driven straight from the raw two-wire bus lines. When the command decoder recognises and acknowledges a step command addressed to this channel, it pulses an arm input. The block then enters step mode. In step mode, every rising edge of the clock line moves the position by one tap, and the level of the data line at that edge gives the direction. Both lines pass through a two-flop synchronizer and are sampled at the synchronized rising edge. Step mode ends when the block sees a stop condition, or a start condition, on the bus.

A channel number is given by parameter, so several copies can share one bus decoder. Tap 0 is the switch at the low end of the resistor string and tap 63 is the switch at the high end.

Top module: `wiper_counter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `wiper_o` equals `RESET_TAP` (default 0), `tap_o` has only that bit set, and `step_mode_o` is 0.
- R2: `tap_o` always has exactly one bit set, and that bit is `tap_o[wiper_o]`. Code 0x00 enables bit 0, the low-end tap, and code 0x3F enables bit 63, the high-end tap.
- R3: The loads apply on the next clock edge, in this priority: `pwr_load_i` first, then `dir_load_i`, then `par_load_i`. When any load is present, a step event in the same cycle is discarded.
- R4: `arm_i` with `arm_pot_i == CHAN_ID` sets step mode on the next edge. `arm_i` with the other channel number leaves step mode off, and later clock pulses do not change `wiper_o`.
- R5: In step mode, each synchronized rising edge of `scl_i` changes `wiper_o` on the third clock edge after the raw rise is first sampled. With `sda_i` high at that edge the change is +1; with `sda_i` low it is −1.
- R6: Stepping saturates. An increment at 63 leaves 63, and a decrement at 0 leaves 0. There is no wraparound.
- R7: A stop condition (`sda_i` rising while `scl_i` is high) or a start condition (`sda_i` falling while `scl_i` is high) clears step mode. Later clock pulses do not change `wiper_o`. The clock rise that opens a stop or start sequence is still a step while the mode is active.
- R8: When step mode is off, clock pulses on `scl_i` have no effect on `wiper_o` for any level of `sda_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line (asynchronous) |
| sda_i | input | 1 | Raw bus data line (asynchronous) |
| arm_i | input | 1 | One-cycle pulse: step command acknowledged |
| arm_pot_i | input | 1 | Channel number carried by the step command |
| pwr_load_i | input | 1 | Power-up recall strobe |
| pwr_val_i | input | 6 | Power-up recall value |
| dir_load_i | input | 1 | Direct write strobe from the bus |
| dir_val_i | input | 6 | Direct write value |
| par_load_i | input | 1 | Parallel load strobe from a storage register |
| par_val_i | input | 6 | Parallel load value |
| wiper_o | output | 6 | Current tap position |
| tap_o | output | 64 | One-hot tap switch enables |
| step_mode_o | output | 1 | Step mode active |

## Verification
The assertions check the following on every cycle:

- the one-hot shape of `tap_o` and its agreement with `wiper_o`;
- the priority of the loads;
- that the position never moves by more than one tap without a load;
- that the position never wraps at either end;
- that it holds still while neither a load nor step mode is present.

Some behaviour depends on the raw bus waveforms, and only the bench scenarios can show it:

- the synchronizer latency;
- the direction taken from the data level;
- the rejection of an arm for the other channel;
- the end of step mode at stop and start conditions.

// File: rtl/wc_pkg.sv
package wc_pkg;
    localparam int unsigned TAP_BITS = 6;
    localparam int unsigned NUM_TAPS = 1 << TAP_BITS;
    localparam int unsigned SYNC_STAGES = 2;

    typedef logic [TAP_BITS-1:0] tap_t;
    typedef logic [NUM_TAPS-1:0] tap_vec_t;

    localparam tap_t TAP_MAX = tap_t'(NUM_TAPS - 1);

    typedef struct packed {
        logic rise;
        logic stop;
        logic start;
        logic level;
    } bus_ev_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } wop_e;

    typedef struct packed {
        wop_e op;
        tap_t val;
    } wcmd_t;

    function automatic tap_t step_sat(input tap_t cur, input logic up);
        if (up) begin
            return (cur == TAP_MAX) ? cur : cur + tap_t'(1);
        end
        return (cur == '0) ? cur : cur - tap_t'(1);
    endfunction
endpackage

// File: rtl/wc_bus_sync.sv
module wc_bus_sync
    import wc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [SYNC_STAGES:0] scl_sh;
    logic [SYNC_STAGES:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_sh[SYNC_STAGES-1];
    assign scl_old = scl_sh[SYNC_STAGES];
    assign sda_now = sda_sh[SYNC_STAGES-1];
    assign sda_old = sda_sh[SYNC_STAGES];

    always_comb begin
        ev_o.rise  = scl_now & ~scl_old;
        ev_o.stop  = scl_now & scl_old & sda_now & ~sda_old;
        ev_o.start = scl_now & scl_old & ~sda_now & sda_old;
        ev_o.level = sda_now;
    end
endmodule

// File: rtl/wc_mode.sv
module wc_mode
    import wc_pkg::*;
#(
    parameter logic CHAN_ID = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    arm_i,
    input  logic    arm_pot_i,
    input  bus_ev_t ev_i,
    output logic    mode_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= 1'b0;
        end else if (arm_i && (arm_pot_i == CHAN_ID)) begin
            mode_o <= 1'b1;
        end else if (ev_i.stop || ev_i.start) begin
            mode_o <= 1'b0;
        end
    end
endmodule

// File: rtl/wc_arbiter.sv
module wc_arbiter
    import wc_pkg::*;
(
    input  logic    pwr_load_i,
    input  tap_t    pwr_val_i,
    input  logic    dir_load_i,
    input  tap_t    dir_val_i,
    input  logic    par_load_i,
    input  tap_t    par_val_i,
    input  logic    mode_i,
    input  bus_ev_t ev_i,
    output wcmd_t   cmd_o
);
    always_comb begin
        cmd_o.op  = OP_HOLD;
        cmd_o.val = '0;
        if (pwr_load_i) begin
            cmd_o.op  = OP_LOAD;
            cmd_o.val = pwr_val_i;
        end else if (dir_load_i) begin
            cmd_o.op  = OP_LOAD;
            cmd_o.val = dir_val_i;
        end else if (par_load_i) begin
            cmd_o.op  = OP_LOAD;
            cmd_o.val = par_val_i;
        end else if (mode_i && ev_i.rise) begin
            cmd_o.op = ev_i.level ? OP_UP : OP_DOWN;
        end
    end
endmodule

// File: rtl/wc_reg.sv
module wc_reg
    import wc_pkg::*;
#(
    parameter tap_t RESET_TAP = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  wcmd_t cmd_i,
    output tap_t  wiper_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wiper_o <= RESET_TAP;
        end else begin
            unique case (cmd_i.op)
                OP_LOAD: wiper_o <= cmd_i.val;
                OP_UP:   wiper_o <= step_sat(wiper_o, 1'b1);
                OP_DOWN: wiper_o <= step_sat(wiper_o, 1'b0);
                default: wiper_o <= wiper_o;
            endcase
        end
    end
endmodule

// File: rtl/wc_decode.sv
module wc_decode
    import wc_pkg::*;
(
    input  tap_t     wiper_i,
    output tap_vec_t tap_o
);
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_o[i] = (wiper_i == tap_t'(i));
    end
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
    import wc_pkg::*;
#(
    parameter logic CHAN_ID   = 1'b0,
    parameter tap_t RESET_TAP = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       arm_i,
    input  logic       arm_pot_i,
    input  logic       pwr_load_i,
    input  logic [5:0] pwr_val_i,
    input  logic       dir_load_i,
    input  logic [5:0] dir_val_i,
    input  logic       par_load_i,
    input  logic [5:0] par_val_i,
    output logic [5:0] wiper_o,
    output logic [63:0] tap_o,
    output logic       step_mode_o
);
    bus_ev_t ev;
    wcmd_t   cmd;
    logic    mode_q;
    tap_t    wiper_q;

    wc_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    wc_mode #(.CHAN_ID(CHAN_ID)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm_i),
        .arm_pot_i (arm_pot_i),
        .ev_i      (ev),
        .mode_o    (mode_q)
    );

    wc_arbiter u_arb (
        .pwr_load_i (pwr_load_i),
        .pwr_val_i  (pwr_val_i),
        .dir_load_i (dir_load_i),
        .dir_val_i  (dir_val_i),
        .par_load_i (par_load_i),
        .par_val_i  (par_val_i),
        .mode_i     (mode_q),
        .ev_i       (ev),
        .cmd_o      (cmd)
    );

    wc_reg #(.RESET_TAP(RESET_TAP)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .wiper_o (wiper_q)
    );

    wc_decode u_dec (
        .wiper_i (wiper_q),
        .tap_o   (tap_o)
    );

    assign wiper_o     = wiper_q;
    assign step_mode_o = mode_q;
endmodule

// File: rtl/wiper_counter_chk.sv
module wiper_counter_chk (
    input logic        clk,
    input logic        rst,
    input logic        pwr_load_i,
    input logic [5:0]  pwr_val_i,
    input logic        dir_load_i,
    input logic [5:0]  dir_val_i,
    input logic        par_load_i,
    input logic [5:0]  par_val_i,
    input logic [5:0]  wiper_o,
    input logic [63:0] tap_o,
    input logic        step_mode_o
);
    logic any_load;
    assign any_load = pwr_load_i | dir_load_i | par_load_i;

    // R2: one-hot tap enables that agree with the position
    a_r2_onehot_tap: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_o) == 1);
    a_r2_tap_matches: assert property (@(posedge clk) disable iff (rst)
        tap_o[wiper_o] == 1'b1);

    // R3: load priority
    a_r3_pwr_first: assert property (@(posedge clk) disable iff (rst)
        pwr_load_i |=> wiper_o == $past(pwr_val_i));
    a_r3_dir_second: assert property (@(posedge clk) disable iff (rst)
        (dir_load_i && !pwr_load_i) |=> wiper_o == $past(dir_val_i));
    a_r3_par_third: assert property (@(posedge clk) disable iff (rst)
        (par_load_i && !dir_load_i && !pwr_load_i) |=> wiper_o == $past(par_val_i));

    // R5: without a load, the position moves by at most one tap
    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        !any_load |=> (wiper_o == $past(wiper_o)) ||
                      (wiper_o == 6'($past(wiper_o) + 6'd1)) ||
                      (wiper_o == 6'($past(wiper_o) - 6'd1)));

    // R6: no wraparound at either end
    a_r6_no_wrap_high: assert property (@(posedge clk) disable iff (rst)
        (wiper_o == 6'd63 && !any_load) |=> wiper_o != 6'd0);
    a_r6_no_wrap_low: assert property (@(posedge clk) disable iff (rst)
        (wiper_o == 6'd0 && !any_load) |=> wiper_o != 6'd63);

    // R8: with neither a load nor step mode, the position holds
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!any_load && !step_mode_o) |=> $stable(wiper_o));
endmodule

bind wiper_counter wiper_counter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_load_i  (pwr_load_i),
    .pwr_val_i   (pwr_val_i),
    .dir_load_i  (dir_load_i),
    .dir_val_i   (dir_val_i),
    .par_load_i  (par_load_i),
    .par_val_i   (par_val_i),
    .wiper_o     (wiper_o),
    .tap_o       (tap_o),
    .step_mode_o (step_mode_o)
);

// File: tb/test_wiper_counter.sv
module test_wiper_counter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 0;
    logic rst = 1;
    logic scl = 1, sda = 1, arm = 0, arm_pot = 0;
    logic pwr_ld = 0, dir_ld = 0, par_ld = 0;
    logic [5:0] pwr_v = 0, dir_v = 0, par_v = 0;
    logic [5:0] wiper;
    logic [63:0] tap;
    logic smode;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_counter i_wiper_counter (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .arm_i(arm), .arm_pot_i(arm_pot),
        .pwr_load_i(pwr_ld), .pwr_val_i(pwr_v),
        .dir_load_i(dir_ld), .dir_val_i(dir_v),
        .par_load_i(par_ld), .par_val_i(par_v),
        .wiper_o(wiper), .tap_o(tap), .step_mode_o(smode)
    );

    // Behavioural reference: a queue of bus samples and an integer position
    bit scl_q[$];
    bit sda_q[$];
    int m_pos;
    bit m_mode;

    always @(posedge clk) begin
        if (rst) begin
            scl_q = '{1, 1, 1};
            sda_q = '{1, 1, 1};
            m_pos = 0;
            m_mode = 0;
        end else begin
            bit rise, stp, sta, lvl;
            rise = scl_q[1] && !scl_q[2];
            stp  = scl_q[1] && scl_q[2] && sda_q[1] && !sda_q[2];
            sta  = scl_q[1] && scl_q[2] && !sda_q[1] && sda_q[2];
            lvl  = sda_q[1];
            if (pwr_ld) m_pos = pwr_v;
            else if (dir_ld) m_pos = dir_v;
            else if (par_ld) m_pos = par_v;
            else if (m_mode && rise) begin
                if (lvl) m_pos = (m_pos < 63) ? m_pos + 1 : 63;
                else     m_pos = (m_pos > 0) ? m_pos - 1 : 0;
            end
            if (arm && arm_pot == 1'b0) m_mode = 1;
            else if (stp || sta) m_mode = 0;
            scl_q.push_front(scl); void'(scl_q.pop_back());
            sda_q.push_front(sda); void'(sda_q.pop_back());
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R2, R5)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(wiper == 6'(m_pos), "R5 model position", 64'(wiper), 64'(m_pos));
            chk(tap == (64'd1 << m_pos), "R2 model tap", tap, 64'd1 << m_pos);
            chk(smode == m_mode, "R4 model mode", 64'(smode), 64'(m_mode));
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit d);
        @(negedge clk); scl = 0; sda = d;
        wait_cyc(3); scl = 1;
        wait_cyc(4); scl = 0;
        wait_cyc(3);
    endtask

    task automatic do_arm(input bit pot);
        @(negedge clk); scl = 0; sda = 0;
        wait_cyc(4);
        arm = 1; arm_pot = pot;
        @(negedge clk); arm = 0;
        wait_cyc(2);
    endtask

    task automatic dload(input logic [5:0] v);
        @(negedge clk); dir_ld = 1; dir_v = v;
        @(negedge clk); dir_ld = 0;
    endtask

    initial begin
        wait_cyc(WATCHDOG);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        // R1 reset state
        chk(wiper == 0, "R1 reset wiper", 64'(wiper), 0);
        chk(tap == 64'd1, "R1 reset tap", tap, 64'd1);
        chk(smode == 0, "R1 reset mode", 64'(smode), 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(wiper == 0, "R1 after reset", 64'(wiper), 0);

        // R3 priority: power recall beats direct and parallel
        pwr_ld = 1; pwr_v = 37; dir_ld = 1; dir_v = 5; par_ld = 1; par_v = 9;
        @(negedge clk); pwr_ld = 0;
        chk(wiper == 37, "R3 power recall wins", 64'(wiper), 37);
        @(negedge clk); dir_ld = 0;
        chk(wiper == 5, "R3 direct beats parallel", 64'(wiper), 5);
        @(negedge clk); par_ld = 0;
        chk(wiper == 9, "R3 parallel load", 64'(wiper), 9);

        // R8 pulses with no step mode
        pulse(1); pulse(1); pulse(0);
        chk(wiper == 9, "R8 no mode no step", 64'(wiper), 9);

        // R4 arm for the other channel is ignored
        do_arm(1);
        chk(smode == 0, "R4 foreign arm", 64'(smode), 0);
        pulse(1); pulse(1);
        chk(wiper == 9, "R4 foreign arm no step", 64'(wiper), 9);

        // R5 stepping in both directions
        do_arm(0);
        chk(smode == 1, "R4 own arm", 64'(smode), 1);
        for (int i = 0; i < 5; i++) pulse(1);
        chk(wiper == 14, "R5 five increments", 64'(wiper), 14);
        pulse(0); pulse(0);
        chk(wiper == 12, "R5 two decrements", 64'(wiper), 12);

        // R3 load beats a step in the same cycle
        @(negedge clk); par_ld = 1; par_v = 20;
        pulse(1);
        @(negedge clk); par_ld = 0;
        @(negedge clk);
        chk(wiper == 20, "R3 load over step", 64'(wiper), 20);

        // R6 saturation at the top and bottom
        dload(60);
        for (int i = 0; i < 8; i++) pulse(1);
        chk(wiper == 63, "R6 saturate high", 64'(wiper), 63);
        chk(tap == 64'h8000_0000_0000_0000, "R2 high-end tap", tap, 64'h8000_0000_0000_0000);
        dload(2);
        for (int i = 0; i < 5; i++) pulse(0);
        chk(wiper == 0, "R6 saturate low", 64'(wiper), 0);
        pulse(1); pulse(1); pulse(1);
        chk(wiper == 3, "R5 climb from zero", 64'(wiper), 3);

        // R7 stop: rise with SDA low (one decrement), then SDA rises with SCL high
        @(negedge clk); scl = 0; sda = 0;
        wait_cyc(3); scl = 1;
        wait_cyc(3); sda = 1;
        wait_cyc(4);
        chk(smode == 0, "R7 stop ends mode", 64'(smode), 0);
        chk(wiper == 2, "R7 stop clock step", 64'(wiper), 2);
        pulse(1); pulse(0);
        chk(wiper == 2, "R7 no step after stop", 64'(wiper), 2);

        // R7 start: rise with SDA high (one increment), then SDA falls with SCL high
        do_arm(0);
        chk(smode == 1, "R4 rearm", 64'(smode), 1);
        @(negedge clk); scl = 0; sda = 1;
        wait_cyc(3); scl = 1;
        wait_cyc(3); sda = 0;
        wait_cyc(4);
        chk(smode == 0, "R7 start ends mode", 64'(smode), 0);
        chk(wiper == 3, "R7 start clock step", 64'(wiper), 3);
        pulse(1);
        chk(wiper == 3, "R7 no step after start", 64'(wiper), 3);

        wait_cyc(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule